// File: doc/BRIEF.md
# Exception Dispatch and State Update Unit

This block sits beside a processor pipeline and turns a raised exception into a vector choice plus a set of special-register updates. A general exception (a cause code, the faulting PC and, optionally, a faulting virtual address) is steered to the kernel, user or double vector according to the exception-mode and user-mode bits of the status word. A debug request takes a separate path. It is honoured only when the current interrupt level is below the configured debug level, and it saves the PC and the whole old status word into the registers kept for that level.

Requests use a raise/acknowledge handshake. The requester holds its request high until it sees the acknowledge, which arrives one cycle after the accepting edge. On that same cycle every register update becomes visible and a one-cycle redirect pulse appears with a 2-bit vector code. The status word is owned here. The core may overwrite it through a load port, for example when it returns from a handler. Status word layout: interrupt level in bits 3:0, exception mode in bit 4, user mode in bit 5. Any higher bits are carried through unchanged. Vector codes: 0 kernel, 1 user, 2 double, 3 debug.

Top module: `exc_dispatch_unit`

## Requirements
- R1: A general exception accepted while the exception-mode bit (bit 4) is clear writes its PC to `epc1` and yields vector code 1 when the user-mode bit (bit 5) is set and vector code 0 when it is clear.
- R2: A general exception accepted while bit 4 is set yields vector code 2. Its PC goes to `depc` when `HAS_DEPC` is 1, leaving `epc1` unchanged, and to `epc1` when `HAS_DEPC` is 0.
- R3: Every accepted general exception writes its cause to `exccause` and sets bit 4 of the status word, leaving all other status bits as they were.
- R4: `excvaddr` takes `gen_vaddr` only on an accepted general exception with `gen_has_vaddr` high, and keeps its value otherwise.
- R5: A debug request is taken only when status bits 3:0 are strictly less than `DEBUG_LEVEL`. Otherwise it is still acknowledged, but it produces no redirect and changes no register.
- R6: A taken debug request writes `dbg_cause` to `dbgcause` and `dbg_pc` to `epc_dbg`, and copies the status word from before the update into `eps_dbg`.
- R7: A taken debug request sets status bits 3:0 to `DEBUG_LEVEL` and sets bit 4, keeping bit 5 and the higher bits. It yields vector code 3.
- R8: When a debug request that will be taken and a general request are raised in the same cycle, the debug request is served first. The general request stays pending and is served on a later edge against the status word the debug update left.
- R9: Each accepted request produces exactly one acknowledge pulse and one redirect pulse (for a taken request), both visible in the cycle after the accepting edge and gone in the cycle after that.
- R10: `ps_load` writes `ps_load_val` into the status word on an edge where no exception is accepted. It is ignored on an edge where one is accepted.
- R11: After reset, every saved register reads 0, `redirect`, `gen_ack` and `dbg_ack` are low, and the status word equals `PS_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | General exception raised, held until `gen_ack` |
| gen_pc | input | ADDR_W | PC of the faulting instruction |
| gen_cause | input | CAUSE_W | Cause code for `exccause` |
| gen_has_vaddr | input | 1 | The exception carries a faulting address |
| gen_vaddr | input | ADDR_W | Faulting virtual address |
| gen_ack | output | 1 | General request accepted (one-cycle pulse) |
| dbg_req | input | 1 | Debug exception raised, held until `dbg_ack` |
| dbg_pc | input | ADDR_W | PC to save on a debug exception |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| dbg_ack | output | 1 | Debug request consumed, taken or dropped (one-cycle pulse) |
| ps_load | input | 1 | Overwrite the status word |
| ps_load_val | input | PS_W | Value for the status word |
| redirect | output | 1 | One-cycle pulse: fetch must go to the vector in `vec` |
| vec | output | 2 | Vector code: 0 kernel, 1 user, 2 double, 3 debug |
| ps | output | PS_W | Current status word |
| epc1 | output | ADDR_W | Saved PC for first-level exceptions |
| depc | output | ADDR_W | Saved PC for double exceptions (0 when `HAS_DEPC`=0) |
| exccause | output | CAUSE_W | Last general cause |
| excvaddr | output | ADDR_W | Last faulting virtual address |
| dbgcause | output | DCAUSE_W | Last debug cause |
| epc_dbg | output | ADDR_W | Saved PC for the debug level |
| eps_dbg | output | PS_W | Saved status word for the debug level |

## Verification
The in-line properties check on every cycle that the vector code agrees with the status bits held before the update. They also check that a debug redirect implies a level below the debug level and leaves the status word at the debug level with exception mode set, that acknowledges are single pulses, that a debug redirect never coincides with a general acknowledge, and that `excvaddr` holds without an address-carrying exception. What only the scenarios can show is where each PC lands, the exact cause values, that a dropped debug request leaves every register untouched, that a pending general request is later served through the double vector, and that a status load collides correctly with an exception.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

   typedef enum logic [1:0] {
      VEC_KERNEL = 2'd0,
      VEC_USER   = 2'd1,
      VEC_DOUBLE = 2'd2,
      VEC_DEBUG  = 2'd3
   } exc_vec_e;

   localparam int PS_LVL_LSB  = 0;
   localparam int PS_LVL_W    = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;
   localparam int PS_MIN_W    = 6;

endpackage

// File: rtl/exc_gen_sel.sv
module exc_gen_sel
   import exc_dispatch_pkg::*;
#(
   parameter int PS_W     = 8,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic [PS_W-1:0] ps_cur,
   output exc_vec_e        vec_sel,
   output logic            to_depc,
   output logic [PS_W-1:0] ps_next
);

   logic in_excm;
   logic in_user;

   assign in_excm = ps_cur[PS_EXCM_BIT];
   assign in_user = ps_cur[PS_UM_BIT];

   always_comb begin
      if (in_excm)
         vec_sel = VEC_DOUBLE;
      else if (in_user)
         vec_sel = VEC_USER;
      else
         vec_sel = VEC_KERNEL;
   end

   generate
      if (HAS_DEPC) begin : g_depc
         assign to_depc = in_excm;
      end else begin : g_no_depc
         assign to_depc = 1'b0;
      end
   endgenerate

   always_comb begin
      ps_next = ps_cur;
      ps_next[PS_EXCM_BIT] = 1'b1;
   end

endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate
   import exc_dispatch_pkg::*;
#(
   parameter int PS_W        = 8,
   parameter int DEBUG_LEVEL = 6
) (
   input  logic [PS_W-1:0] ps_cur,
   output logic            allow,
   output logic [PS_W-1:0] ps_next
);

   localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

   logic [PS_LVL_W-1:0] cur_lvl;

   assign cur_lvl = ps_cur[PS_LVL_LSB +: PS_LVL_W];
   assign allow   = (cur_lvl < DBG_LVL);

   always_comb begin
      ps_next = ps_cur;
      ps_next[PS_LVL_LSB +: PS_LVL_W] = DBG_LVL;
      ps_next[PS_EXCM_BIT] = 1'b1;
   end

endmodule

// File: rtl/exc_dispatch_unit.sv
module exc_dispatch_unit
   import exc_dispatch_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter int          CAUSE_W     = 6,
   parameter int          DCAUSE_W    = 6,
   parameter int          PS_W        = 8,
   parameter int          DEBUG_LEVEL = 6,
   parameter bit          HAS_DEPC    = 1'b1,
   parameter logic [PS_W-1:0] PS_RESET = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gen_req,
   input  logic [ADDR_W-1:0]   gen_pc,
   input  logic [CAUSE_W-1:0]  gen_cause,
   input  logic                gen_has_vaddr,
   input  logic [ADDR_W-1:0]   gen_vaddr,
   output logic                gen_ack,
   input  logic                dbg_req,
   input  logic [ADDR_W-1:0]   dbg_pc,
   input  logic [DCAUSE_W-1:0] dbg_cause,
   output logic                dbg_ack,
   input  logic                ps_load,
   input  logic [PS_W-1:0]     ps_load_val,
   output logic                redirect,
   output logic [1:0]          vec,
   output logic [PS_W-1:0]     ps,
   output logic [ADDR_W-1:0]   epc1,
   output logic [ADDR_W-1:0]   depc,
   output logic [CAUSE_W-1:0]  exccause,
   output logic [ADDR_W-1:0]   excvaddr,
   output logic [DCAUSE_W-1:0] dbgcause,
   output logic [ADDR_W-1:0]   epc_dbg,
   output logic [PS_W-1:0]     eps_dbg
);

   localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

   // elaboration-time parameter checks
   generate
      if (PS_W < PS_MIN_W) begin : g_bad_psw
         $error("PS_W must hold level, exception-mode and user-mode fields");
      end
      if (DEBUG_LEVEL < 2 || DEBUG_LEVEL > 15) begin : g_bad_lvl
         $error("DEBUG_LEVEL must lie in 2..15");
      end
      if (ADDR_W < 2 || CAUSE_W < 1 || DCAUSE_W < 1) begin : g_bad_w
         $error("address and cause widths must be positive");
      end
   endgenerate

   // state
   logic                gen_ack_q, dbg_ack_q, redirect_q;
   exc_vec_e            vec_q;
   logic [PS_W-1:0]     ps_q;
   logic [ADDR_W-1:0]   epc1_q, depc_q, excvaddr_q, epc_dbg_q;
   logic [CAUSE_W-1:0]  exccause_q;
   logic [DCAUSE_W-1:0] dbgcause_q;
   logic [PS_W-1:0]     eps_dbg_q;

   // path decisions
   exc_vec_e        gen_vec;
   logic            gen_to_depc;
   logic [PS_W-1:0] gen_ps_next;
   logic            dbg_allow;
   logic [PS_W-1:0] dbg_ps_next;

   exc_gen_sel #(.PS_W(PS_W), .HAS_DEPC(HAS_DEPC)) u_gen_sel (
      .ps_cur  (ps_q),
      .vec_sel (gen_vec),
      .to_depc (gen_to_depc),
      .ps_next (gen_ps_next)
   );

   exc_dbg_gate #(.PS_W(PS_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_dbg_gate (
      .ps_cur  (ps_q),
      .allow   (dbg_allow),
      .ps_next (dbg_ps_next)
   );

   logic dbg_acc, dbg_take, gen_acc;

   assign dbg_acc  = dbg_req & ~dbg_ack_q;
   assign dbg_take = dbg_acc & dbg_allow;
   assign gen_acc  = gen_req & ~gen_ack_q & ~dbg_take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_ack_q  <= 1'b0;
         dbg_ack_q  <= 1'b0;
         redirect_q <= 1'b0;
         vec_q      <= VEC_KERNEL;
         ps_q       <= PS_RESET;
         epc1_q     <= '0;
         excvaddr_q <= '0;
         exccause_q <= '0;
         dbgcause_q <= '0;
         epc_dbg_q  <= '0;
         eps_dbg_q  <= '0;
      end else begin
         gen_ack_q  <= gen_acc;
         dbg_ack_q  <= dbg_acc;
         redirect_q <= dbg_take | gen_acc;
         if (dbg_take) begin
            dbgcause_q <= dbg_cause;
            epc_dbg_q  <= dbg_pc;
            eps_dbg_q  <= ps_q;
            ps_q       <= dbg_ps_next;
            vec_q      <= VEC_DEBUG;
         end else if (gen_acc) begin
            exccause_q <= gen_cause;
            if (gen_has_vaddr)
               excvaddr_q <= gen_vaddr;
            if (!gen_to_depc)
               epc1_q <= gen_pc;
            ps_q  <= gen_ps_next;
            vec_q <= gen_vec;
         end else if (ps_load) begin
            ps_q <= ps_load_val;
         end
      end
   end

   generate
      if (HAS_DEPC) begin : g_depc_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               depc_q <= '0;
            else if (!dbg_take && gen_acc && gen_to_depc)
               depc_q <= gen_pc;
         end
      end else begin : g_depc_none
         assign depc_q = '0;
      end
   endgenerate

   assign gen_ack  = gen_ack_q;
   assign dbg_ack  = dbg_ack_q;
   assign redirect = redirect_q;
   assign vec      = vec_q;
   assign ps       = ps_q;
   assign epc1     = epc1_q;
   assign depc     = depc_q;
   assign exccause = exccause_q;
   assign excvaddr = excvaddr_q;
   assign dbgcause = dbgcause_q;
   assign epc_dbg  = epc_dbg_q;
   assign eps_dbg  = eps_dbg_q;

   // in-line properties
   assert_first_level_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_q && (vec_q == VEC_KERNEL || vec_q == VEC_USER)) |->
         (!$past(ps_q[PS_EXCM_BIT]) &&
          ((vec_q == VEC_USER) == $past(ps_q[PS_UM_BIT])) &&
          (epc1_q == $past(gen_pc))));

   assert_double_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_q && vec_q == VEC_DOUBLE) |-> $past(ps_q[PS_EXCM_BIT]));

   assert_gen_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gen_ack_q |-> (ps_q[PS_EXCM_BIT] && exccause_q == $past(gen_cause)));

   assert_vaddr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(gen_acc && gen_has_vaddr) |-> $stable(excvaddr_q));

   assert_dbg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_q && vec_q == VEC_DEBUG) |->
         ($past(ps_q[PS_LVL_LSB +: PS_LVL_W]) < DBG_LVL));

   assert_dbg_ps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_q && vec_q == VEC_DEBUG) |->
         (ps_q[PS_LVL_LSB +: PS_LVL_W] == DBG_LVL && ps_q[PS_EXCM_BIT] &&
          eps_dbg_q == $past(ps_q)));

   assert_dbg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_q && vec_q == VEC_DEBUG) |-> !gen_ack_q);

   assert_gen_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gen_ack_q |=> !gen_ack_q);

   assert_dbg_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack_q |=> !dbg_ack_q);

endmodule

// File: tb/exc_dispatch_unit_tb.sv
`timescale 1ns/1ps
module exc_dispatch_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gen_req = 1'b0;
   logic [31:0] gen_pc = '0;
   logic [5:0]  gen_cause = '0;
   logic        gen_has_vaddr = 1'b0;
   logic [31:0] gen_vaddr = '0;
   logic        gen_ack;
   logic        dbg_req = 1'b0;
   logic [31:0] dbg_pc = '0;
   logic [5:0]  dbg_cause = '0;
   logic        dbg_ack;
   logic        ps_load = 1'b0;
   logic [7:0]  ps_load_val = '0;
   logic        redirect;
   logic [1:0]  vec;
   logic [7:0]  ps;
   logic [31:0] epc1, depc, excvaddr, epc_dbg;
   logic [5:0]  exccause, dbgcause;
   logic [7:0]  eps_dbg;

   always #2.5 clk = ~clk;

   exc_dispatch_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .gen_req(gen_req), .gen_pc(gen_pc), .gen_cause(gen_cause),
      .gen_has_vaddr(gen_has_vaddr), .gen_vaddr(gen_vaddr), .gen_ack(gen_ack),
      .dbg_req(dbg_req), .dbg_pc(dbg_pc), .dbg_cause(dbg_cause), .dbg_ack(dbg_ack),
      .ps_load(ps_load), .ps_load_val(ps_load_val),
      .redirect(redirect), .vec(vec), .ps(ps), .epc1(epc1), .depc(depc),
      .exccause(exccause), .excvaddr(excvaddr), .dbgcause(dbgcause),
      .epc_dbg(epc_dbg), .eps_dbg(eps_dbg)
   );

   // stimulus / expectation table (debug level 6, double PC register present)
   typedef struct packed {
      logic [7:0] ps0;
      logic       is_dbg;
      logic       has_va;
      logic [5:0] cause;
      logic       exp_red;
      logic [1:0] exp_vec;
      logic [7:0] exp_ps;
      logic [1:0] pc_dst;   // 0 epc1, 1 depc, 2 epc_dbg, 3 none
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [0:NV-1] = '{
      '{8'h00, 1'b0, 1'b1, 6'd3,  1'b1, 2'd0, 8'h10, 2'd0},
      '{8'h20, 1'b0, 1'b0, 6'd5,  1'b1, 2'd1, 8'h30, 2'd0},
      '{8'h10, 1'b0, 1'b1, 6'd9,  1'b1, 2'd2, 8'h10, 2'd1},
      '{8'h30, 1'b0, 1'b0, 6'd12, 1'b1, 2'd2, 8'h30, 2'd1},
      '{8'h03, 1'b1, 1'b0, 6'd1,  1'b1, 2'd3, 8'h16, 2'd2},
      '{8'h25, 1'b1, 1'b0, 6'd4,  1'b1, 2'd3, 8'h36, 2'd2},
      '{8'h06, 1'b1, 1'b0, 6'd2,  1'b0, 2'd0, 8'h06, 2'd3},
      '{8'h0F, 1'b1, 1'b0, 6'd8,  1'b0, 2'd0, 8'h0F, 2'd3},
      '{8'h15, 1'b1, 1'b0, 6'd16, 1'b1, 2'd3, 8'h16, 2'd2},
      '{8'hC2, 1'b0, 1'b1, 6'd28, 1'b1, 2'd0, 8'hD2, 2'd0}
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_epc1 = '0, m_depc = '0, m_epcd = '0, m_va = '0;
   logic [5:0]  m_cause = '0, m_dcause = '0;
   logic [7:0]  m_eps = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      chk({tag, " R1 epc1"}, epc1, m_epc1);
      chk({tag, " R2 depc"}, depc, m_depc);
      chk({tag, " R3 exccause"}, 32'(exccause), 32'(m_cause));
      chk({tag, " R4 excvaddr"}, excvaddr, m_va);
      chk({tag, " R6 dbgcause"}, 32'(dbgcause), 32'(m_dcause));
      chk({tag, " R6 epc_dbg"}, epc_dbg, m_epcd);
      chk({tag, " R6 eps_dbg"}, 32'(eps_dbg), 32'(m_eps));
   endtask

   task automatic load_ps(input logic [7:0] v);
      @(negedge clk);
      ps_load = 1'b1;
      ps_load_val = v;
      @(negedge clk);
      ps_load = 1'b0;
      chk("R10 ps load", 32'(ps), 32'(v));
   endtask

   task automatic run_vec(input int i);
      vec_t e;
      logic [31:0] pc;
      logic [31:0] va;
      e  = TBL[i];
      pc = 32'h1000_0000 + 32'(i) * 32'h10;
      va = 32'hA000_0000 | 32'(i);
      load_ps(e.ps0);
      if (e.is_dbg) begin
         dbg_req = 1'b1; dbg_pc = pc; dbg_cause = e.cause;
      end else begin
         gen_req = 1'b1; gen_pc = pc; gen_cause = e.cause;
         gen_has_vaddr = e.has_va; gen_vaddr = va;
      end
      @(negedge clk);
      // bench model of the register updates
      if (e.is_dbg) begin
         if (e.exp_red) begin
            m_dcause = e.cause; m_epcd = pc; m_eps = e.ps0;
         end
         chk("R9 dbg_ack", 32'(dbg_ack), 32'd1);
      end else begin
         m_cause = e.cause;
         if (e.has_va) m_va = va;
         if (e.pc_dst == 2'd1) m_depc = pc; else m_epc1 = pc;
         chk("R9 gen_ack", 32'(gen_ack), 32'd1);
      end
      chk("R5 R9 redirect", 32'(redirect), 32'(e.exp_red));
      if (e.exp_red) chk("R1 R2 R7 vec", 32'(vec), 32'(e.exp_vec));
      chk("R3 R5 R7 ps", 32'(ps), 32'(e.exp_ps));
      chk_regs("table");
      dbg_req = 1'b0; gen_req = 1'b0; gen_has_vaddr = 1'b0;
      @(negedge clk);
      chk("R9 redirect drop", 32'(redirect), 32'd0);
      chk("R9 ack drop", 32'({gen_ack, dbg_ack}), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 ps reset", 32'(ps), 32'h00);
      chk("R11 redirect reset", 32'(redirect), 32'd0);
      chk("R11 acks reset", 32'({gen_ack, dbg_ack}), 32'd0);
      chk_regs("R11 reset");
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R8: debug and general raised together
      load_ps(8'h00);
      gen_req = 1'b1; gen_pc = 32'h2000_0100; gen_cause = 6'd7;
      dbg_req = 1'b1; dbg_pc = 32'h2000_0200; dbg_cause = 6'd2;
      @(negedge clk);
      m_dcause = 6'd2; m_epcd = 32'h2000_0200; m_eps = 8'h00;
      chk("R8 debug first vec", 32'(vec), 32'd3);
      chk("R8 debug ack", 32'(dbg_ack), 32'd1);
      chk("R8 general held", 32'(gen_ack), 32'd0);
      chk("R8 ps after debug", 32'(ps), 32'h16);
      dbg_req = 1'b0;
      @(negedge clk);
      m_cause = 6'd7; m_depc = 32'h2000_0100;
      chk("R8 general served", 32'(gen_ack), 32'd1);
      chk("R8 R2 double vec", 32'(vec), 32'd2);
      chk("R8 redirect", 32'(redirect), 32'd1);
      chk("R8 ps kept", 32'(ps), 32'h16);
      chk_regs("R8");
      gen_req = 1'b0;
      @(negedge clk);

      // R10: status load ignored when an exception is accepted
      load_ps(8'h00);
      ps_load = 1'b1; ps_load_val = 8'h20;
      gen_req = 1'b1; gen_pc = 32'h3000_0000; gen_cause = 6'd9;
      @(negedge clk);
      ps_load = 1'b0; gen_req = 1'b0;
      m_cause = 6'd9; m_epc1 = 32'h3000_0000;
      chk("R10 R1 kernel vec", 32'(vec), 32'd0);
      chk("R10 ps load ignored", 32'(ps), 32'h10);
      chk_regs("R10");
      load_ps(8'h2A);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule